// File: doc/BRIEF.md
# Translation RAM character dispatcher

This block sits in a printer data path. Every character that arrives addresses a 256-word by 12-bit translation table. The upper four bits of the addressed word are flags. Those flags, plus one sticky bit carried over from the previous character, choose one of four outcomes:

- pass the incoming byte through unchanged;
- emit the low byte of the table word instead;
- hand a vertical-format command to the paper-motion logic;
- stop the stream and flag the character as undefined.

The block also keeps a running 8-bit sum of every character it accepts. The table is filled one word per cycle through a write port.

Downstream logic formats the printed characters and moves the paper. It reads `act_valid`, `act_kind` and `act_data`. After an undefined-character stop, a `start` pulse lets the stream run again. The same pulse also begins a new checksum.

Top module: `char_action_dispatcher`

## Requirements
- R1: After reset, all of these read zero: `act_valid`, `halted`, `undef_flag`, `hold_flag`, `checksum` and `last_entry`.
- R2: A write with `wr_en` stores `wr_data` at `wr_addr`. A later character with that code gets that word. The word appears on `last_entry` one cycle after the character is accepted.
- R3: A table word holds four flags: bit 11 means stop, bit 10 means delimiter, bit 9 means translate and bit 8 means paper. The outcome depends only on these four bits and on `hold_flag`.
- R4: Case where the stop flag is set:
  - if translate is clear, or delimiter is set, or `hold_flag` is set, the outcome is an undefined stop;
  - otherwise, if paper is set, the outcome is a format command;
  - otherwise it is a translated print.
- R5: Case where stop is clear and paper is set: if translate, delimiter or `hold_flag` is set, the outcome is a format command. Otherwise it is a raw print.
- R6: Case where both stop and paper are clear: if translate, delimiter or `hold_flag` is set, the outcome is a translated print. Otherwise it is a raw print.
- R7: After each accepted character, `hold_flag` takes the delimiter bit (bit 10) of that character's word. The next character's dispatch uses this new value.
- R8: `act_kind` encodes the outcome as 0 = raw, 1 = translated, 2 = format. `act_data` carries the input byte for a raw print and word bits 7:0 for the other two. For a format command, `fmt_slew` gives word bit 4 (1 = advance lines, 0 = skip to channel) and `fmt_arg` gives word bits 3:0.
- R9: An undefined stop works as follows:
  - it sets `undef_flag` and `halted` and produces no `act_valid`;
  - while `halted` is set, characters are ignored, with no action and no change to the checksum or `hold_flag`;
  - `start` clears `halted`;
  - `undef_flag` clears when the next character is accepted.
- R10: `checksum` is the sum modulo 256 of all accepted characters, the stopping one included. `start` zeroes it. A character presented in the same cycle as `start` is dropped.
- R11: Each accepted character produces its outcome on the outputs exactly one cycle later. `act_valid` is a one-cycle pulse and never appears with the undefined outcome.
- R12: If a table write and a lookup hit the same address in the same cycle, the lookup returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new transfer: zero the checksum and release a halt |
| chr_valid | input | 1 | Character present |
| chr_data | input | 8 | Character code, also the table address |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table write address |
| wr_data | input | 12 | Table write word |
| act_valid | output | 1 | Action pulse for the character accepted in the previous cycle |
| act_kind | output | 2 | Outcome code (0 raw, 1 translated, 2 format, 3 undefined) |
| act_data | output | 8 | Byte to print, or format word bits 7:0 |
| fmt_slew | output | 1 | Format command: 1 advance lines, 0 skip to channel |
| fmt_arg | output | 4 | Line count or channel number |
| halted | output | 1 | Stream stopped by an undefined character |
| undef_flag | output | 1 | Last accepted character was undefined |
| hold_flag | output | 1 | Delimiter bit of the last accepted word |
| checksum | output | 8 | Running byte sum |
| last_entry | output | 12 | Table word of the last accepted character |

## Verification
A wrong `hold_flag` shows up only one character later, as a changed outcome for the following character. The bench therefore pairs a priming character that sets or clears the bit with a probe character, and sweeps all 32 flag/hold combinations. A stuck halt or an unblocked stream shows on `act_valid` and `checksum` in the cycle after the ignored character. A table write that lands at the wrong time or address shows on `act_data` and `last_entry` one cycle after the lookup.

// File: rtl/chd_pkg.sv
package chd_pkg;

  typedef enum logic [1:0] {
    ACT_RAW  = 2'd0,
    ACT_XLAT = 2'd1,
    ACT_FMT  = 2'd2,
    ACT_INT  = 2'd3
  } act_e;

  // Outcome for one flag nibble {stop, delim, xlat, paper} and the hold bit.
  function automatic act_e pick_action(input logic [3:0] fl, input logic hd);
    logic stp, dlm, xl, pap, mod;
    stp = fl[3];
    dlm = fl[2];
    xl  = fl[1];
    pap = fl[0];
    mod = xl | dlm | hd;
    if (stp) begin
      if (!xl || dlm || hd) return ACT_INT;
      else if (pap)         return ACT_FMT;
      else                  return ACT_XLAT;
    end else if (pap) begin
      return mod ? ACT_FMT : ACT_RAW;
    end else begin
      return mod ? ACT_XLAT : ACT_RAW;
    end
  endfunction

endpackage

// File: rtl/chd_table_ram.sv
module chd_table_ram #(
  parameter int ADDR_W  = 8,
  parameter int ENTRY_W = 12
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Asynchronous read: a same-cycle write is seen only by later lookups.
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/chd_action_sel.sv
module chd_action_sel
  import chd_pkg::*;
(
  input  logic [3:0] flags,
  input  logic       hold,
  output act_e       action
);
  localparam int CASES = 32;

  act_e tbl [CASES];

  // Case table computed from the dispatch rules, one entry per {flags, hold}.
  for (genvar g = 0; g < CASES; g++) begin : g_case
    assign tbl[g] = pick_action(4'(g / 2), 1'(g % 2));
  end

  assign action = tbl[{flags, hold}];

endmodule

// File: rtl/chd_csum.sv
module chd_csum #(
  parameter int DIN_W  = 8,
  parameter int CSUM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DIN_W-1:0]  din,
  output logic [CSUM_W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= sum + CSUM_W'(din);
  end

endmodule

// File: rtl/char_action_dispatcher.sv
module char_action_dispatcher
  import chd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ENTRY_W = 12,
  parameter int CSUM_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chr_valid,
  input  logic [ADDR_W-1:0]  chr_data,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic               act_valid,
  output logic [1:0]         act_kind,
  output logic [7:0]         act_data,
  output logic               fmt_slew,
  output logic [3:0]         fmt_arg,
  output logic               halted,
  output logic               undef_flag,
  output logic               hold_flag,
  output logic [CSUM_W-1:0]  checksum,
  output logic [ENTRY_W-1:0] last_entry
);
  localparam int FLAG_HI = ENTRY_W - 1;
  localparam int DELIM_B = ENTRY_W - 2;
  localparam int FLAG_LO = ENTRY_W - 4;

  logic [ENTRY_W-1:0] entry;
  act_e               action;
  logic               accept_evt;
  logic               int_evt;

  // Accept a character unless stopped or being restarted this cycle.
  assign accept_evt = chr_valid && !halted && !start;
  assign int_evt    = accept_evt && (action == ACT_INT);

  chd_table_ram #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (chr_data),
    .rd_data (entry)
  );

  chd_action_sel u_sel (
    .flags  (entry[FLAG_HI:FLAG_LO]),
    .hold   (hold_flag),
    .action (action)
  );

  chd_csum #(.DIN_W(ADDR_W), .CSUM_W(CSUM_W)) u_csum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .add   (accept_evt),
    .din   (chr_data),
    .sum   (checksum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid  <= 1'b0;
      act_kind   <= 2'd0;
      act_data   <= '0;
      halted     <= 1'b0;
      undef_flag <= 1'b0;
      hold_flag  <= 1'b0;
      last_entry <= '0;
    end else begin
      act_valid <= 1'b0;
      if (start) halted <= 1'b0;
      if (accept_evt) begin
        last_entry <= entry;
        hold_flag  <= entry[DELIM_B];
        undef_flag <= (action == ACT_INT);
        halted     <= (action == ACT_INT);
        act_valid  <= (action != ACT_INT);
        act_kind   <= action;
        act_data   <= (action == ACT_RAW) ? 8'(chr_data) : entry[7:0];
      end
    end
  end

  assign fmt_slew = act_data[4];
  assign fmt_arg  = act_data[3:0];

  // R9: a halted stream produces no action in the following cycle
  p_halt_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !act_valid);

  // R9: an undefined character stops the stream and raises the flag
  p_int_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int_evt |=> (halted && undef_flag && !act_valid));

  // R10: start zeroes the sum
  p_csum_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (checksum == '0));

  // R10: each accepted byte adds into the sum
  p_csum_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (checksum == CSUM_W'($past(checksum) + CSUM_W'($past(chr_data)))));

  // R7: hold follows the delimiter bit of the word just looked up
  p_hold_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (hold_flag == $past(entry[DELIM_B])));

  // R11: no action pulse without an accepted character
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> !act_valid);

  // R11: the pulse never carries the undefined outcome
  p_pulse_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (act_kind != 2'd3));

endmodule

// File: tb/char_action_dispatcher_test.sv
module char_action_dispatcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        chr_valid = 1'b0;
  logic [7:0]  chr_data = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        act_valid;
  logic [1:0]  act_kind;
  logic [7:0]  act_data;
  logic        fmt_slew;
  logic [3:0]  fmt_arg;
  logic        halted;
  logic        undef_flag;
  logic        hold_flag;
  logic [7:0]  checksum;
  logic [11:0] last_entry;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  char_action_dispatcher uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chr_valid(chr_valid),
    .chr_data(chr_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_valid(act_valid), .act_kind(act_kind), .act_data(act_data),
    .fmt_slew(fmt_slew), .fmt_arg(fmt_arg), .halted(halted),
    .undef_flag(undef_flag), .hold_flag(hold_flag), .checksum(checksum),
    .last_entry(last_entry)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    chr_valid = 1'b1; chr_data = c;
    @(negedge clk);
    chr_valid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [7:0] low_of(input int f);
    return 8'(f * 29 + 3);
  endfunction

  // Expected outcome: 0 raw, 1 translated, 2 format, 3 undefined.
  function automatic logic [1:0] expect_kind(input logic [3:0] f, input logic h);
    logic any;
    any = f[1] | f[2] | h;
    if (f[3]) begin
      if (!(f[1] && !f[2] && !h)) return 2'd3;
      return f[0] ? 2'd2 : 2'd1;
    end
    if (f[0]) return any ? 2'd2 : 2'd0;
    return any ? 2'd1 : 2'd0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 act_valid", act_valid, 0);
    chk("R1 halted", halted, 0);
    chk("R1 undef", undef_flag, 0);
    chk("R1 hold", hold_flag, 0);
    chk("R1 checksum", checksum, 0);
    chk("R1 last_entry", last_entry, 0);
    rst_n = 1'b1;

    // Fill the table: 0 plain, 1 delimiter only, 2 translate 0xAA, 16..31 sweep words.
    for (int a = 0; a < 256; a++) begin
      logic [11:0] w;
      if (a == 1) w = 12'h400;
      else if (a == 2) w = 12'h2AA;
      else if (a >= 16 && a < 32) w = {4'(a - 16), low_of(a - 16)};
      else w = 12'h000;
      wr(8'(a), w);
    end

    // Sweep all 16 flag nibbles against both hold values (R3..R8, R10).
    for (int f = 0; f < 16; f++) begin
      for (int h = 0; h < 2; h++) begin
        logic [1:0] ek;
        logic [7:0] ed;
        restart();
        send(8'(h));
        chk("R7 hold primed", hold_flag, 32'(h));
        send(8'(16 + f));
        ek = expect_kind(4'(f), 1'(h));
        ed = (ek == 2'd0) ? 8'(16 + f) : low_of(f);
        if (f >= 8) chk("R4 kind", act_kind, ek);
        else if (f % 2 == 1) chk("R5 kind", act_kind, ek);
        else chk("R6 kind", act_kind, ek);
        chk("R3 act_valid", act_valid, (ek != 2'd3) ? 1 : 0);
        if (ek != 2'd3) chk("R8 act_data", act_data, ed);
        if (ek == 2'd2) begin
          chk("R8 fmt_slew", fmt_slew, ed[4]);
          chk("R8 fmt_arg", fmt_arg, ed[3:0]);
        end
        chk("R9 halted", halted, (ek == 2'd3) ? 1 : 0);
        chk("R9 undef", undef_flag, (ek == 2'd3) ? 1 : 0);
        chk("R7 hold", hold_flag, (f >> 2) & 1);
        chk("R2 last_entry", last_entry, {20'd0, 4'(f), low_of(f)});
        chk("R10 checksum", checksum, 32'(h + 16 + f));
        @(negedge clk);
        chk("R11 pulse", act_valid, 0);
      end
    end

    // R9: a halted stream ignores characters; start releases it.
    restart();
    send(8'd24);                       // flags 1000: undefined
    chk("R9 halted after stop", halted, 1);
    send(8'd1);                        // would set hold if accepted
    chk("R9 ignored act", act_valid, 0);
    chk("R9 ignored checksum", checksum, 24);
    chk("R9 ignored hold", hold_flag, 0);
    chk("R9 undef kept", undef_flag, 1);
    restart();
    chk("R9 released", halted, 0);
    send(8'd0);
    chk("R9 undef cleared", undef_flag, 0);
    chk("R9 resumed act", act_valid, 1);

    // R10: wrap modulo 256, and start beats a same-cycle character.
    restart();
    send(8'd200);
    send(8'd100);
    chk("R10 wrap", checksum, 44);
    @(negedge clk);
    start = 1'b1; chr_valid = 1'b1; chr_data = 8'd7;
    @(negedge clk);
    start = 1'b0; chr_valid = 1'b0;
    chk("R10 start wins sum", checksum, 0);
    chk("R10 start wins act", act_valid, 0);

    // R12: same-cycle write and lookup returns the old word.
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd2; wr_data = 12'h255;
    chr_valid = 1'b1; chr_data = 8'd2;
    @(negedge clk);
    wr_en = 1'b0; chr_valid = 1'b0;
    chk("R12 old word", act_data, 8'hAA);
    send(8'd2);
    chk("R2 new word", act_data, 8'h55);
    chk("R2 new entry", last_entry, 12'h255);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule